// File: doc/BRIEF.md
# Next-Fit Page Range Allocator

This block hands out contiguous runs of pages from a fixed pool of remapping pages, tracked in a register bitmap where a set bit marks a used page. An allocation request supplies a page count, an alignment mask and an exclusive upper page limit. The block answers with the first suitable starting page, or with a failure. A free request clears a run of bits. The lowest pages of the pool are reserved for overflow handling. They are used from reset and can never be granted or released.

The search is next-fit. It starts at a saved pointer that follows the end of the previous grant, and it tests one bitmap bit per clock. The pointer can go back to page 0 in three ways: the limit sits at or below the pointer, a pass from a non-zero pointer finds nothing and a second pass from 0 runs, or a grant ends at the top of the pool. Each of these raises a deferred-flush flag. In full-flush mode every allocation raises the flag. A separate flush command consumes the flag. When the flag was set, the command produces a one-cycle invalidate pulse for a downstream translation cache.

Requests are taken only while `busy` is low. When several arrive in the same cycle, allocation has priority over free, and free has priority over flush.

Top module: `page_range_alloc`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `flush_issue` are low, the deferred-flush flag is clear, the search pointer is 0, and every page below RESV_PAGES (32) is used while every other page is free.
- R2: A search starts at the saved pointer, not at page 0. After a grant the pointer becomes offset plus count.
- R3: If the limit (clamped to NPAGES) is at or below the pointer when a request is accepted, the pointer is set to 0, the search starts at 0 and the flush flag is set.
- R4: If a pass that started at a non-zero page finds no fit, exactly one more pass runs from page 0 and the flush flag is set.
- R5: When offset plus count of a grant reaches NPAGES, the pointer becomes 0 and the flush flag is set.
- R6: While `full_flush_en` is high, every allocation (granted or failed, count non-zero) sets the flush flag.
- R7: No page below RESV_PAGES is ever granted, and a free request covering such pages leaves them used.
- R8: A granted offset satisfies (offset AND align mask) = 0. All of its pages were free, and offset plus count is at most the clamped limit. Among the candidates of a pass it is the lowest.
- R9: A free request clears exactly the pages offset to offset+count-1 (those at or above RESV_PAGES and below NPAGES) and no others.
- R10: A failed allocation gives `done` and `fail` high with `result` all ones, and it leaves the bitmap unchanged. A count of 0 always fails this way without touching pointer or flag.
- R11: A flush command pulses `flush_issue` for one cycle on the following cycle and clears the flag only if the flag was set. Otherwise it has no effect.
- R12: Requests are accepted only while `busy` is low, with priority allocate > free > flush. `busy` is high from the cycle after an accepted non-zero-count allocation until its result. `done` is a one-cycle pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| full_flush_en | input | 1 | Every allocation sets the flush flag |
| alloc_req | input | 1 | Allocation request |
| alloc_count | input | 8 | Number of pages requested |
| alloc_align | input | 7 | Alignment mask the start page must clear |
| alloc_limit | input | 8 | Exclusive upper page limit (clamped to NPAGES) |
| free_req | input | 1 | Free request |
| free_offset | input | 7 | First page to free |
| free_count | input | 8 | Number of pages to free |
| flush_req | input | 1 | Flush command |
| busy | output | 1 | Search in progress; requests ignored |
| done | output | 1 | One-cycle pulse with an allocation result |
| fail | output | 1 | Allocation failed (valid with done) |
| result | output | 7 | Granted start page, all ones on failure |
| flush_issue | output | 1 | One-cycle invalidate pulse after a flush command |

## Verification
Directed sequences each build a known bitmap and pointer. They separate next-fit from first-fit by freeing a hole behind the pointer. They separate a rewind caused by a low limit from a retry after a failed pass, and a retry that succeeds from one that fails. A grant that ends exactly at the top of the pool shows the wrap flag apart from the other flag sources. Free requests that overlap the reserved area, and requests that arrive while the block is busy or together with a higher-priority request, show whether the bitmap is touched. A long pseudo-random mix of allocations, frees and flushes with varied alignment masks and limits is compared against an exhaustive search model.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/page_alloc_bitmap.sv
module page_alloc_bitmap #(
  parameter int NPAGES     = 128,
  parameter int RESV_PAGES = 32,
  parameter int IW         = $clog2(NPAGES),
  parameter int CW         = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_off,
  input  logic [CW-1:0] set_cnt,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_off,
  input  logic [CW-1:0] clr_cnt,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_used
);

  logic [NPAGES-1:0] used_vec;

  for (genvar g = 0; g < NPAGES; g++) begin : g_page
    if (g < RESV_PAGES) begin : g_resv
      // reserved pages are permanently used
      assign used_vec[g] = 1'b1;
    end else begin : g_pool
      logic bit_q, bit_n, hit_set, hit_clr;

      always_comb begin
        hit_set = set_en && (g >= int'(set_off)) &&
                  (g < int'(set_off) + int'(set_cnt));
        hit_clr = clr_en && (g >= int'(clr_off)) &&
                  (g < int'(clr_off) + int'(clr_cnt));
        bit_n = bit_q;
        if (hit_set)      bit_n = 1'b1;
        else if (hit_clr) bit_n = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bit_q <= 1'b0;
        else if (hit_set | hit_clr) bit_q <= bit_n;
      end

      assign used_vec[g] = bit_q;
    end
  end

  assign rd_used = used_vec[rd_idx];

endmodule

// File: rtl/page_alloc_scan.sv
module page_alloc_scan
  import page_alloc_pkg::*;
#(
  parameter int NPAGES = 128,
  parameter int IW     = $clog2(NPAGES),
  parameter int CW     = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] req_cnt,
  input  logic [IW-1:0] req_align,
  input  logic [CW-1:0] req_limit,
  input  logic          full_flush,
  input  logic          rd_used,
  output logic [IW-1:0] rd_idx,
  output logic          busy,
  output logic          claim_en,
  output logic [IW-1:0] claim_off,
  output logic [CW-1:0] claim_cnt,
  output logic          flag_set,
  output logic          done,
  output logic          fail,
  output logic [IW-1:0] result
);

  localparam logic [CW-1:0] NP_C  = CW'(NPAGES);
  localparam logic [CW:0]   NP_W  = (CW+1)'(NPAGES);

  scan_state_e   state_q, state_n;
  logic [CW-1:0] idx_q, idx_n;
  logic [CW-1:0] run_q, run_n;
  logic [CW-1:0] cand_q, cand_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] lim_q, lim_n;
  logic [CW-1:0] next_q, next_n;
  logic [IW-1:0] align_q, align_n;
  logic          zero_q, zero_n;
  logic          ffl_q, ffl_n;
  logic          done_q, done_n;
  logic          fail_q, fail_n;
  logic [IW-1:0] res_q, res_n;

  logic [CW-1:0] lim_clamp;
  logic [CW:0]   fit_end;
  logic [CW:0]   grant_end;
  logic [CW-1:0] found;
  logic          at_end, aligned;
  logic          data_en;

  always_comb begin
    lim_clamp = (req_limit > NP_C) ? NP_C : req_limit;
    fit_end   = {1'b0, idx_q} + {1'b0, cnt_q};
    at_end    = (run_q == '0) && (fit_end > {1'b0, lim_q});
    aligned   = (idx_q[IW-1:0] & align_q) == '0;
    found     = (run_q == '0) ? idx_q : cand_q;
    grant_end = {1'b0, found} + {1'b0, cnt_q};
  end

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    run_n     = run_q;
    cand_n    = cand_q;
    cnt_n     = cnt_q;
    lim_n     = lim_q;
    next_n    = next_q;
    align_n   = align_q;
    zero_n    = zero_q;
    ffl_n     = ffl_q;
    done_n    = 1'b0;
    fail_n    = 1'b0;
    res_n     = res_q;
    flag_set  = 1'b0;
    claim_en  = 1'b0;
    claim_off = found[IW-1:0];
    claim_cnt = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (req_cnt == '0) begin
            done_n = 1'b1;
            fail_n = 1'b1;
            res_n  = '1;
          end else begin
            cnt_n   = req_cnt;
            align_n = req_align;
            lim_n   = lim_clamp;
            ffl_n   = full_flush;
            run_n   = '0;
            state_n = ST_SCAN;
            if (lim_clamp <= next_q) begin
              flag_set = 1'b1;
              next_n   = '0;
              idx_n    = '0;
              zero_n   = 1'b1;
            end else begin
              idx_n  = next_q;
              zero_n = (next_q == '0);
            end
          end
        end
      end
      ST_SCAN: begin
        if (at_end) begin
          if (!zero_q) begin
            flag_set = 1'b1;
            idx_n    = '0;
            run_n    = '0;
            zero_n   = 1'b1;
          end else begin
            flag_set = ffl_q;
            done_n   = 1'b1;
            fail_n   = 1'b1;
            res_n    = '1;
            state_n  = ST_IDLE;
          end
        end else if ((run_q == '0) && !aligned) begin
          idx_n = idx_q + 1'b1;
        end else if (rd_used) begin
          run_n = '0;
          idx_n = idx_q + 1'b1;
        end else if (run_q + 1'b1 == cnt_q) begin
          claim_en = 1'b1;
          done_n   = 1'b1;
          res_n    = found[IW-1:0];
          state_n  = ST_IDLE;
          if (grant_end >= NP_W) begin
            next_n   = '0;
            flag_set = 1'b1;
          end else begin
            next_n = grant_end[CW-1:0];
          end
          if (ffl_q) flag_set = 1'b1;
        end else begin
          if (run_q == '0) cand_n = idx_q;
          run_n = run_q + 1'b1;
          idx_n = idx_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign data_en = start || (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      next_q  <= '0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      fail_q  <= fail_n;
      next_q  <= next_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      run_q   <= '0;
      cand_q  <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
      align_q <= '0;
      zero_q  <= 1'b0;
      ffl_q   <= 1'b0;
      res_q   <= '0;
    end else if (data_en) begin
      idx_q   <= idx_n;
      run_q   <= run_n;
      cand_q  <= cand_n;
      cnt_q   <= cnt_n;
      lim_q   <= lim_n;
      align_q <= align_n;
      zero_q  <= zero_n;
      ffl_q   <= ffl_n;
      res_q   <= res_n;
    end
  end

  assign rd_idx = idx_q[IW-1:0];
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign fail   = fail_q;
  assign result = res_q;

endmodule

// File: rtl/page_alloc_flush.sv
module page_alloc_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_set,
  input  logic flush_go,
  output logic issue
);

  logic pend_q, pend_n;
  logic issue_q, issue_n;

  always_comb begin
    issue_n = flush_go && pend_q;
    pend_n  = (pend_q && !issue_n) || flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      issue_q <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      issue_q <= issue_n;
    end
  end

  assign issue = issue_q;

endmodule

// File: rtl/page_range_alloc.sv
module page_range_alloc #(
  parameter int NPAGES     = 128,
  parameter int RESV_PAGES = 32,
  localparam int IW        = $clog2(NPAGES),
  localparam int CW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_flush_en,
  input  logic          alloc_req,
  input  logic [CW-1:0] alloc_count,
  input  logic [IW-1:0] alloc_align,
  input  logic [CW-1:0] alloc_limit,
  input  logic          free_req,
  input  logic [IW-1:0] free_offset,
  input  logic [CW-1:0] free_count,
  input  logic          flush_req,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [IW-1:0] result,
  output logic          flush_issue
);

  logic          rst_s1_q, rst_s2_q;
  logic          rst_int_n;
  logic          busy_w;
  logic          go_alloc, go_free, go_flush;
  logic          rd_used;
  logic [IW-1:0] rd_idx;
  logic          claim_en;
  logic [IW-1:0] claim_off;
  logic [CW-1:0] claim_cnt;
  logic          flag_set;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  always_comb begin
    go_alloc = !busy_w && alloc_req;
    go_free  = !busy_w && !alloc_req && free_req;
    go_flush = !busy_w && !alloc_req && !free_req && flush_req;
  end

  page_alloc_bitmap #(
    .NPAGES(NPAGES), .RESV_PAGES(RESV_PAGES), .IW(IW), .CW(CW)
  ) map_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (claim_en),
    .set_off (claim_off),
    .set_cnt (claim_cnt),
    .clr_en  (go_free),
    .clr_off (free_offset),
    .clr_cnt (free_count),
    .rd_idx  (rd_idx),
    .rd_used (rd_used)
  );

  page_alloc_scan #(
    .NPAGES(NPAGES), .IW(IW), .CW(CW)
  ) scan_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (go_alloc),
    .req_cnt    (alloc_count),
    .req_align  (alloc_align),
    .req_limit  (alloc_limit),
    .full_flush (full_flush_en),
    .rd_used    (rd_used),
    .rd_idx     (rd_idx),
    .busy       (busy_w),
    .claim_en   (claim_en),
    .claim_off  (claim_off),
    .claim_cnt  (claim_cnt),
    .flag_set   (flag_set),
    .done       (done),
    .fail       (fail),
    .result     (result)
  );

  page_alloc_flush flush_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flag_set (flag_set),
    .flush_go (go_flush),
    .issue    (flush_issue)
  );

  assign busy = busy_w;

endmodule

// File: rtl/page_range_alloc_chk.sv
module page_range_alloc_chk #(
  parameter int NPAGES     = 128,
  parameter int RESV_PAGES = 32,
  parameter int IW         = $clog2(NPAGES),
  parameter int CW         = IW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_req,
  input logic [CW-1:0] alloc_count,
  input logic [IW-1:0] alloc_align,
  input logic [CW-1:0] alloc_limit,
  input logic          free_req,
  input logic          flush_req,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [IW-1:0] result,
  input logic          flush_issue
);

  localparam logic [CW-1:0] NP_C = CW'(NPAGES);

  logic          take;
  logic [CW-1:0] cnt_l, lim_l;
  logic [IW-1:0] al_l;

  assign take = !busy && alloc_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_l <= '0;
      lim_l <= '0;
      al_l  <= '0;
    end else if (take) begin
      cnt_l <= alloc_count;
      lim_l <= (alloc_limit > NP_C) ? NP_C : alloc_limit;
      al_l  <= alloc_align;
    end
  end

  p_busy_after_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    take && (alloc_count != '0) |=> busy);

  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_fail_all_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> (result == '1));

  p_aligned_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> ((result & al_l) == '0));

  p_within_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> (({1'b0, result} + cnt_l) <= lim_l));

  p_no_reserved_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> (int'(result) >= RESV_PAGES));

  p_issue_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_issue |-> $past(flush_req && !busy && !alloc_req && !free_req));

endmodule

bind page_range_alloc page_range_alloc_chk #(
  .NPAGES(NPAGES), .RESV_PAGES(RESV_PAGES), .IW(IW), .CW(CW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_req   (alloc_req),
  .alloc_count (alloc_count),
  .alloc_align (alloc_align),
  .alloc_limit (alloc_limit),
  .free_req    (free_req),
  .flush_req   (flush_req),
  .busy        (busy),
  .done        (done),
  .fail        (fail),
  .result      (result),
  .flush_issue (flush_issue)
);

// File: tb/page_range_alloc_tb_top.sv
`timescale 1ns/1ps
module page_range_alloc_tb_top;

  localparam int NP   = 128;
  localparam int RESV = 32;
  localparam int IW   = 7;
  localparam int CW   = 8;

  logic          clk;
  logic          rst_n;
  logic          full_flush_en;
  logic          alloc_req;
  logic [CW-1:0] alloc_count;
  logic [IW-1:0] alloc_align;
  logic [CW-1:0] alloc_limit;
  logic          free_req;
  logic [IW-1:0] free_offset;
  logic [CW-1:0] free_count;
  logic          flush_req;
  logic          busy, done, fail, flush_issue;
  logic [IW-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  bit m_map [NP];
  int m_next;
  bit m_flag;
  bit m_ffl;
  logic [31:0] lf;

  page_range_alloc #(.NPAGES(NP), .RESV_PAGES(RESV)) dut_i (
    .clk(clk), .rst_n(rst_n), .full_flush_en(full_flush_en),
    .alloc_req(alloc_req), .alloc_count(alloc_count),
    .alloc_align(alloc_align), .alloc_limit(alloc_limit),
    .free_req(free_req), .free_offset(free_offset), .free_count(free_count),
    .flush_req(flush_req), .busy(busy), .done(done), .fail(fail),
    .result(result), .flush_issue(flush_issue)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // ---------------- reference model (exhaustive search) ----------------
  function automatic int m_search(int from, int lim, int cnt, int al);
    for (int i = from; i + cnt <= lim; i++) begin
      bit ok;
      if ((i & al) != 0) continue;
      ok = 1'b1;
      for (int j = 0; j < cnt; j++) if (m_map[i+j]) ok = 1'b0;
      if (ok) return i;
    end
    return -1;
  endfunction

  function automatic int m_alloc(int cnt, int al, int lim);
    int l, off;
    if (cnt == 0) return -1;
    l = (lim > NP) ? NP : lim;
    if (l <= m_next) begin m_next = 0; m_flag = 1'b1; end
    off = m_search(m_next, l, cnt, al);
    if (off < 0 && m_next != 0) begin
      m_flag = 1'b1;
      off = m_search(0, l, cnt, al);
    end
    if (off >= 0) begin
      for (int j = 0; j < cnt; j++) m_map[off+j] = 1'b1;
      m_next = off + cnt;
      if (m_next >= NP) begin m_next = 0; m_flag = 1'b1; end
    end
    if (m_ffl) m_flag = 1'b1;
    return off;
  endfunction

  function automatic void m_free(int off, int cnt);
    for (int i = off; i < off + cnt && i < NP; i++)
      if (i >= RESV) m_map[i] = 1'b0;
  endfunction

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    rst_n = 1'b0; full_flush_en = 1'b0; alloc_req = 1'b0; free_req = 1'b0;
    flush_req = 1'b0; alloc_count = '0; alloc_align = '0; alloc_limit = '0;
    free_offset = '0; free_count = '0;
    for (int i = 0; i < NP; i++) m_map[i] = (i < RESV);
    m_next = 0; m_flag = 1'b0; m_ffl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(output bit seen);
    int t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    seen = done;
  endtask

  task automatic do_alloc(input int cnt, input int al, input int lim,
                          input string req, output int got);
    int exp; bit seen;
    exp = m_alloc(cnt, al, lim);
    alloc_req = 1'b1; alloc_count = CW'(cnt); alloc_align = IW'(al);
    alloc_limit = CW'(lim);
    @(negedge clk);
    alloc_req = 1'b0;
    wait_done(seen);
    chk(seen, req, "done pulse", int'(seen), 1);
    chk(fail == (exp < 0), req, "fail flag", int'(fail), int'(exp < 0));
    chk(int'(result) == ((exp < 0) ? (NP - 1) : exp), req, "result",
        int'(result), (exp < 0) ? (NP - 1) : exp);
    got = fail ? -1 : int'(result);
    @(negedge clk);
  endtask

  task automatic do_free(input int off, input int cnt);
    m_free(off, cnt);
    free_req = 1'b1; free_offset = IW'(off); free_count = CW'(cnt);
    @(negedge clk);
    free_req = 1'b0;
  endtask

  task automatic do_flush(input string req, output bit got);
    bit exp;
    exp = m_flag;
    m_flag = 1'b0;
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    chk(flush_issue == exp, req, "flush issue", int'(flush_issue), int'(exp));
    got = flush_issue;
    @(negedge clk);
    chk(flush_issue == 1'b0, req, "flush pulse width", int'(flush_issue), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    bit f; int r;
    do_reset();
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(fail == 1'b0, "R1", "fail after reset", int'(fail), 0);
    chk(flush_issue == 1'b0, "R1", "issue after reset", int'(flush_issue), 0);
    do_flush("R1", f);
    chk(f == 1'b0, "R1", "no flag at reset", int'(f), 0);
    do_alloc(1, 0, 128, "R1", r);
    chk(r == RESV, "R1", "first free page", r, RESV);
  endtask

  task automatic t_next_fit_rewind_retry();
    int r; bit f;
    do_reset();
    do_alloc(4, 0, 128, "R2", r);  chk(r == 32, "R2", "first grant", r, 32);
    do_alloc(3, 3, 128, "R8", r);  chk(r == 36, "R8", "align 4", r, 36);
    do_alloc(2, 7, 128, "R8", r);  chk(r == 40, "R8", "align 8", r, 40);
    do_free(36, 3);
    do_alloc(1, 0, 128, "R2", r);  chk(r == 42, "R2", "next fit skips hole", r, 42);
    do_flush("R11", f);            chk(f == 1'b0, "R11", "no flag pending", int'(f), 0);
    do_alloc(1, 0, 40, "R3", r);   chk(r == 36, "R3", "rewind to 0", r, 36);
    do_flush("R3", f);             chk(f == 1'b1, "R3", "rewind flag", int'(f), 1);
    do_flush("R11", f);            chk(f == 1'b0, "R11", "flag consumed", int'(f), 0);
    do_alloc(4, 3, 40, "R4", r);   chk(r == -1, "R4", "retry also fails", r, -1);
    do_flush("R4", f);             chk(f == 1'b1, "R4", "retry flag", int'(f), 1);
    do_free(32, 4);
    do_alloc(1, 0, 128, "R4", r);
    do_alloc(4, 3, 40, "R4", r);   chk(r == 32, "R4", "retry succeeds", r, 32);
    do_flush("R4", f);             chk(f == 1'b1, "R4", "retry flag 2", int'(f), 1);
  endtask

  task automatic t_wrap_and_fail();
    int r; bit f;
    do_reset();
    do_alloc(96, 0, 128, "R5", r); chk(r == 32, "R5", "fill to top", r, 32);
    do_flush("R5", f);             chk(f == 1'b1, "R5", "wrap flag", int'(f), 1);
    do_alloc(1, 0, 128, "R10", r); chk(r == -1, "R10", "pool full", r, -1);
    do_flush("R10", f);            chk(f == 1'b0, "R10", "no flag on pass from 0", int'(f), 0);
    do_free(100, 1);
    do_alloc(1, 0, 128, "R10", r); chk(r == 100, "R10", "bitmap unchanged by fail", r, 100);
    do_alloc(0, 0, 128, "R10", r); chk(r == -1, "R10", "zero count", r, -1);
    do_flush("R10", f);            chk(f == 1'b0, "R10", "zero count no flag", int'(f), 0);
  endtask

  task automatic t_free_exact();
    int r;
    do_reset();
    do_alloc(4, 0, 128, "R9", r);
    do_free(33, 2);
    do_alloc(3, 0, 36, "R9", r);   chk(r == -1, "R9", "neighbours kept", r, -1);
    do_alloc(2, 0, 36, "R9", r);   chk(r == 33, "R9", "freed run", r, 33);
  endtask

  task automatic t_reserved();
    int r;
    do_reset();
    do_free(0, 40);
    do_alloc(1, 0, 128, "R7", r);  chk(r == 32, "R7", "reserved still used", r, 32);
    do_free(0, 32);
    do_alloc(1, 0, 33, "R7", r);   chk(r == -1, "R7", "no reserved grant", r, -1);
  endtask

  task automatic t_full_flush();
    int r; bit f;
    do_reset();
    full_flush_en = 1'b1; m_ffl = 1'b1;
    do_alloc(1, 0, 128, "R6", r);
    do_flush("R6", f);             chk(f == 1'b1, "R6", "flag each grant", int'(f), 1);
    do_alloc(1, 0, 128, "R6", r);  chk(r == 33, "R6", "second grant", r, 33);
    do_flush("R6", f);             chk(f == 1'b1, "R6", "flag again", int'(f), 1);
    full_flush_en = 1'b0; m_ffl = 1'b0;
    do_alloc(1, 0, 128, "R6", r);
    do_flush("R6", f);             chk(f == 1'b0, "R6", "mode off", int'(f), 0);
  endtask

  task automatic t_busy_priority();
    int r, exp; bit seen;
    do_reset();
    do_alloc(4, 0, 128, "R12", r);
    exp = m_alloc(1, 0, 128);
    alloc_req = 1'b1; alloc_count = 8'd1; alloc_align = '0; alloc_limit = 8'd128;
    @(negedge clk);
    alloc_req = 1'b0;
    chk(busy == 1'b1, "R12", "busy while searching", int'(busy), 1);
    free_req = 1'b1; free_offset = 7'd32; free_count = 8'd4;
    @(negedge clk);
    free_req = 1'b0;
    wait_done(seen);
    chk(busy == 1'b0, "R12", "busy low with done", int'(busy), 0);
    chk(int'(result) == exp, "R12", "grant during busy", int'(result), exp);
    @(negedge clk);
    exp = m_alloc(1, 0, 128);
    alloc_req = 1'b1; free_req = 1'b1; free_offset = 7'd32; free_count = 8'd4;
    @(negedge clk);
    alloc_req = 1'b0; free_req = 1'b0;
    wait_done(seen);
    chk(int'(result) == exp, "R12", "alloc wins priority", int'(result), exp);
    @(negedge clk);
    do_alloc(4, 0, 36, "R12", r);  chk(r == -1, "R12", "free was ignored", r, -1);
  endtask

  task automatic t_random();
    int r, v, op, cnt, al, lim; bit f;
    do_reset();
    lf = 32'h1badf00d;
    for (int k = 0; k < 160; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      v  = int'(lf[30:0]);
      op = v % 5;
      cnt = 1 + (v / 5) % 8;
      case ((v / 40) % 4)
        0: al = 0; 1: al = 1; 2: al = 3; default: al = 7;
      endcase
      case ((v / 160) % 4)
        0: lim = 40 + (v / 640) % 89;
        1: lim = 200;
        default: lim = 128;
      endcase
      if (op < 2)       do_alloc(cnt, al, lim, "R8", r);
      else if (op < 4)  do_free(RESV + (v / 7) % (NP - RESV), cnt * 2);
      else              do_flush("R11", f);
    end
  endtask

  initial begin
    t_reset_state();
    t_next_fit_rewind_retry();
    t_wrap_and_fail();
    t_free_exact();
    t_reserved();
    t_full_flush();
    t_busy_priority();
    t_random();
    finish_run();
  end

endmodule